// File: doc/BRIEF.md
# Segmented DAC Code Decoder

This block is the digital front end of an 8-bit current-steering converter whose current array is split into two tiers. It takes an 8-bit sample on the rising clock edge and can translate it from two's complement into offset binary. The upper five bits set how many of 31 equal coarse segments steer their current to the A output. The lower three bits set how many of 7 fine segments, each worth one eighth of a coarse one, do the same. Every segment switch gets a true drive and a complementary drive, so a segment that is not steered to A goes to B.

Samples come in on a valid/ready stream. A word moves into the block on any rising edge where `in_valid` and `in_ready` are both high. `in_ready` drops while the block sleeps. A producer that holds a word through a low `in_ready` loses nothing, and the captured code stays as it was. The switch outputs have no back-pressure: they follow the captured code on every cycle.

The sleep input shuts every switch straight away. After sleep is released, or after reset, a status pin reports the analog output as valid only once a fixed number of clock cycles has gone by.

Top module: `seg_dac_decoder`

## Requirements
- R1: Synchronous active-high reset sets the captured code to 128: `sw_msb_a` has its 16 lowest bits set, `sw_lsb_a` is zero, and `out_valid` is low.
- R2: A word is captured on a rising edge only when `in_valid` and `in_ready` are both high. With `in_valid` low, the switch outputs keep the last captured code.
- R3: With `fmt_twos` low (straight binary), the offset-binary code equals `in_data` unchanged.
- R4: With `fmt_twos` high (two's complement), the offset-binary code equals `in_data` with bit 7 inverted.
- R5: `sw_msb_a[i]` is 1 exactly when code bits [7:3] are greater than i. This is a thermometer code that fills from bit 0 upward.
- R6: `sw_lsb_a[j]` is 1 exactly when code bits [2:0] are greater than j. This is a thermometer code that fills from bit 0 upward.
- R7: 8 times the number of set bits in `sw_msb_a`, plus the number of set bits in `sw_lsb_a`, equals the code. Code 255 sets every A bit, and code 0 clears every A bit.
- R8: While `sleep` is low, `sw_msb_b` is the bitwise inverse of `sw_msb_a`, and `sw_lsb_b` is the bitwise inverse of `sw_lsb_a`.
- R9: While `sleep` is high, all four switch buses are 0 in that same cycle and `in_ready` is low. The captured code is kept and shows again when sleep ends.
- R10: `out_valid` is low while `sleep` is high. It rises on the WAKE_CYCLES-th rising edge after sleep or reset ends, provided sleep stays low over those edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample offered on `in_data` |
| in_ready | output | 1 | Block accepts a sample (low during sleep) |
| in_data | input | 8 | Input sample |
| fmt_twos | input | 1 | 1: two's complement input, 0: straight binary |
| sleep | input | 1 | Power-down request, active high |
| out_valid | output | 1 | Analog output settled after wake-up |
| sw_msb_a | output | 31 | Coarse segment drives toward output A |
| sw_msb_b | output | 31 | Coarse segment drives toward output B |
| sw_lsb_a | output | 7 | Fine segment drives toward output A |
| sw_lsb_b | output | 7 | Fine segment drives toward output B |

## Verification
The bench keeps the default 8-bit word and the 3-bit fine split, which gives 31 coarse and 7 fine segments, so all 256 codes in both input codings stay within a few hundred cycles. It lowers WAKE_CYCLES to 12. That keeps the exact cycle on which `out_valid` rises within reach, both after reset and after a sleep period. The default value models a delay of several microseconds and would make those counts long.

// File: rtl/seg_dac_pkg.sv
package seg_dac_pkg;
  typedef enum logic {
    CODING_BINARY = 1'b0,
    CODING_TWOS   = 1'b1
  } coding_e;
endpackage

// File: rtl/seg_dac_input_reg.sv
module seg_dac_input_reg
  import seg_dac_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              fmt_twos,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] code_q
);
  localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};

  coding_e             coding;
  logic [DATA_W-1:0]   offset_code;

  assign coding = coding_e'(fmt_twos);

  always_comb begin
    if (coding == CODING_TWOS) offset_code = data_in ^ MID_CODE;
    else                       offset_code = data_in;
  end

  always_ff @(posedge clk) begin
    if (rst)       code_q <= MID_CODE;
    else if (load) code_q <= offset_code;
  end
endmodule

// File: rtl/seg_dac_therm.sv
module seg_dac_therm #(
  parameter int IN_W = 5
) (
  input  logic [IN_W-1:0]        bin_in,
  output logic [(2**IN_W)-2:0]   therm_out
);
  localparam int N_OUT = (2**IN_W) - 1;

  for (genvar i = 0; i < N_OUT; i++) begin : g_seg
    assign therm_out[i] = (bin_in > IN_W'(i));
  end
endmodule

// File: rtl/seg_dac_wake.sv
module seg_dac_wake #(
  parameter int WAKE_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep,
  output logic settled
);
  localparam int CNT_W = $clog2(WAKE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WAKE_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || sleep)      cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign settled = (cnt_q == LIMIT) && !sleep;
endmodule

// File: rtl/seg_dac_decoder.sv
module seg_dac_decoder #(
  parameter int DATA_W      = 8,
  parameter int FINE_W      = 3,
  parameter int WAKE_CYCLES = 1000
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                in_valid,
  output logic                                in_ready,
  input  logic [DATA_W-1:0]                   in_data,
  input  logic                                fmt_twos,
  input  logic                                sleep,
  output logic                                out_valid,
  output logic [(2**(DATA_W-FINE_W))-2:0]     sw_msb_a,
  output logic [(2**(DATA_W-FINE_W))-2:0]     sw_msb_b,
  output logic [(2**FINE_W)-2:0]              sw_lsb_a,
  output logic [(2**FINE_W)-2:0]              sw_lsb_b
);
  localparam int COARSE_W = DATA_W - FINE_W;
  localparam int N_COARSE = (2**COARSE_W) - 1;
  localparam int N_FINE   = (2**FINE_W) - 1;

  logic [DATA_W-1:0]   code_q;
  logic [N_COARSE-1:0] coarse_therm;
  logic [N_FINE-1:0]   fine_therm;
  logic                awake;

  assign awake    = !sleep;
  assign in_ready = awake;

  seg_dac_input_reg #(.DATA_W(DATA_W)) u_inreg (
    .clk      (clk),
    .rst      (rst),
    .load     (in_valid && in_ready),
    .fmt_twos (fmt_twos),
    .data_in  (in_data),
    .code_q   (code_q)
  );

  seg_dac_therm #(.IN_W(COARSE_W)) u_coarse (
    .bin_in    (code_q[DATA_W-1:FINE_W]),
    .therm_out (coarse_therm)
  );

  seg_dac_therm #(.IN_W(FINE_W)) u_fine (
    .bin_in    (code_q[FINE_W-1:0]),
    .therm_out (fine_therm)
  );

  seg_dac_wake #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
    .clk     (clk),
    .rst     (rst),
    .sleep   (sleep),
    .settled (out_valid)
  );

  assign sw_msb_a = coarse_therm  & {N_COARSE{awake}};
  assign sw_msb_b = ~coarse_therm & {N_COARSE{awake}};
  assign sw_lsb_a = fine_therm    & {N_FINE{awake}};
  assign sw_lsb_b = ~fine_therm   & {N_FINE{awake}};
endmodule

// File: rtl/seg_dac_decoder_chk.sv
module seg_dac_decoder_chk #(
  parameter int N_COARSE = 31,
  parameter int N_FINE   = 7
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                in_ready,
  input logic                sleep,
  input logic                out_valid,
  input logic [N_COARSE-1:0] sw_msb_a,
  input logic [N_COARSE-1:0] sw_msb_b,
  input logic [N_FINE-1:0]   sw_lsb_a,
  input logic [N_FINE-1:0]   sw_lsb_b
);
  assert_pair_compl_R8: assert property (@(posedge clk) disable iff (rst)
    !sleep |-> (sw_msb_b == ~sw_msb_a) && (sw_lsb_b == ~sw_lsb_a));

  assert_sleep_off_R9: assert property (@(posedge clk) disable iff (rst)
    sleep |-> (sw_msb_a == '0) && (sw_msb_b == '0) && (sw_lsb_a == '0) && (sw_lsb_b == '0));

  assert_coarse_therm_R5: assert property (@(posedge clk) disable iff (rst)
    !sleep |-> ((sw_msb_a + N_COARSE'(1)) & sw_msb_a) == '0);

  assert_fine_therm_R6: assert property (@(posedge clk) disable iff (rst)
    !sleep |-> ((sw_lsb_a + N_FINE'(1)) & sw_lsb_a) == '0);

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid && in_ready) && !sleep && !$past(sleep))
      |-> ($stable(sw_msb_a) && $stable(sw_lsb_a)));

  assert_sleep_status_R10: assert property (@(posedge clk) disable iff (rst)
    sleep |-> !out_valid);

  assert_wake_rise_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> (!sleep && !$past(sleep)));
endmodule

bind seg_dac_decoder seg_dac_decoder_chk #(
  .N_COARSE((2**(DATA_W-FINE_W)) - 1),
  .N_FINE  ((2**FINE_W) - 1)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .sleep     (sleep),
  .out_valid (out_valid),
  .sw_msb_a  (sw_msb_a),
  .sw_msb_b  (sw_msb_b),
  .sw_lsb_a  (sw_lsb_a),
  .sw_lsb_b  (sw_lsb_b)
);

// File: tb/seg_dac_decoder_tb_top.sv
module seg_dac_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WAKE       = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       fmt_twos = 1'b0;
  logic       sleep = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic       out_valid;
  logic [30:0] msb_a, msb_b;
  logic [6:0]  lsb_a, lsb_b;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_dac_decoder #(.WAKE_CYCLES(WAKE)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .fmt_twos(fmt_twos), .sleep(sleep), .out_valid(out_valid),
    .sw_msb_a(msb_a), .sw_msb_b(msb_b), .sw_lsb_a(lsb_a), .sw_lsb_b(lsb_b)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Expected switch pattern for an offset-binary code (R5, R6, R7, R8)
  task automatic check_code(logic [7:0] c, string req);
    logic [31:0] m;
    logic [7:0]  l;
    int          weight;
    m = (32'h1 << c[7:3]) - 32'h1;
    l = (8'h1 << c[2:0]) - 8'h1;
    weight = 8 * $countones(msb_a) + $countones(lsb_a);
    check(msb_a == m[30:0],  req, "msb_a (R5)", int'(msb_a), int'(m[30:0]));
    check(lsb_a == l[6:0],   req, "lsb_a (R6)", int'(lsb_a), int'(l[6:0]));
    check(msb_b == ~m[30:0], req, "msb_b (R8)", int'(msb_b), int'(~m[30:0]));
    check(lsb_b == ~l[6:0],  req, "lsb_b (R8)", int'(lsb_b), int'(~l[6:0]));
    check(weight == int'(c), req, "weight (R7)", weight, int'(c));
  endtask

  task automatic send(logic [7:0] w, bit twos, string tag);
    @(negedge clk);
    in_data  = w;
    fmt_twos = twos;
    in_valid = 1'b1;
    @(posedge clk);
    exp_q.push_back(twos ? (w ^ 8'h80) : w);
    tag_q.push_back(tag);
  endtask

  task automatic idle_drain();
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic wake_count(string tag);
    for (int k = 1; k <= WAKE; k++) begin
      @(negedge clk);
      check(out_valid == (k == WAKE), tag, "out_valid during wake-up (R10)",
            int'(out_valid), int'(k == WAKE));
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  // Scoreboard monitor
  always @(posedge clk) begin : mon
    logic [7:0] c;
    string      t;
    #(CLK_PERIOD/4);
    if (exp_q.size() > 0) begin
      c = exp_q.pop_front();
      t = tag_q.pop_front();
      check_code(c, t);
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    check_code(8'd128, "R1");
    rst = 1'b0;
    wake_count("R10");
    check(in_ready == 1'b1, "R9", "in_ready awake", int'(in_ready), 1);

    // R3: straight binary sweep
    for (int w = 0; w < 256; w++) send(8'(w), 1'b0, "R3");
    idle_drain();
    // R4: two's complement sweep
    for (int w = 0; w < 256; w++) send(8'(w), 1'b1, "R4");
    idle_drain();

    // R7: full-scale corners in both codings
    send(8'hFF, 1'b0, "R7");
    send(8'h00, 1'b0, "R7");
    send(8'h7F, 1'b1, "R7");
    send(8'h80, 1'b1, "R7");
    idle_drain();

    // R2: data changes without in_valid are not captured (code stays 0)
    in_data = 8'hA5;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check_code(8'h00, "R2");
    end

    // R9: sleep forces all switches off, blocks input, keeps the code
    send(8'h9C, 1'b0, "R9");
    idle_drain();
    @(negedge clk);
    sleep = 1'b1;
    #1;
    check(msb_a == '0 && msb_b == '0, "R9", "msb pair asleep", int'(msb_a | msb_b), 0);
    check(lsb_a == '0 && lsb_b == '0, "R9", "lsb pair asleep", int'(lsb_a | lsb_b), 0);
    check(in_ready == 1'b0, "R9", "in_ready asleep", int'(in_ready), 0);
    check(out_valid == 1'b0, "R10", "out_valid asleep", int'(out_valid), 0);
    in_data  = 8'h11;
    in_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check((msb_a | msb_b) == '0 && (lsb_a | lsb_b) == '0, "R9", "switches off",
            int'(msb_a | msb_b | 31'(lsb_a | lsb_b)), 0);
      check(out_valid == 1'b0, "R10", "out_valid asleep", int'(out_valid), 0);
    end
    in_valid = 1'b0;
    @(negedge clk);
    sleep = 1'b0;
    #1;
    check_code(8'h9C, "R9");
    check(out_valid == 1'b0, "R10", "out_valid at release", int'(out_valid), 0);
    wake_count("R10");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule